// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block is the 8-bit status register of one channel in a multi-channel 16-bit timer. It watches the channel's counter value and its count-direction signal. It latches an overflow flag when the counter wraps upward and an underflow flag when the counter wraps downward. It also reports the current count direction. The parameter `CHAN_IDX` selects the channel, and the channel decides which bits are implemented and which are fixed reserved bits.

Software clears a flag in two steps. It first reads the flag while the flag is 1, which arms that flag. It then writes 0 to the flag's bit position. Software cannot set a flag. Channel 4 has two extra paths. In complementary PWM mode, an approach to zero from 0x0001 also sets the overflow flag. The overflow flag can also be cleared by a strobe from the transfer controller. Two interrupt-request outputs follow the flags. The register bus is a plain decoded read strobe, write strobe and data bus. No stream interface is involved, so no valid/ready handshake applies.

Top module: `tmr_chan_status`

## Requirements
- R1: After reset, `reg_rdata` is 0xC0 on every channel, and `irq_ovf` and `irq_unf` are 0.
- R2: On channels 1 to 4, bit 7 reads 1 if `cnt_up` was 1 in the previous cycle and 0 if it was 0. On channel 0, bit 7 always reads 1.
- R3: Bit 6 always reads 1. Bits 3..0 always read 0, and writing 1s to them changes no readable bit.
- R4: When `cnt_val` changes from 0xFFFF in one cycle to 0x0000 in the next, the overflow flag (bit 4) reads 1 from the following cycle.
- R5: On channels 1 and 2, when `cnt_val` changes from 0x0000 to 0xFFFF while `phase_mode` is 1, the underflow flag (bit 5) is set. The same change with `phase_mode` at 0 does not set it. On channels 0, 3 and 4, bit 5 always reads 0.
- R6: A write with 0 in a flag's bit position clears that flag only if a read strobe saw that flag at 1 since the flag's last clear. A 0 write without such a read leaves the flag set.
- R7: Writing 1 to a flag bit never sets or clears it.
- R8: If a set event and a qualifying clear write fall in the same cycle, the flag stays 1.
- R9: On channel 4 with `cpwm_mode` at 1, a change of `cnt_val` from 0x0001 to 0x0000 sets the overflow flag. Other channels ignore this case.
- R10: On channel 4, a cycle with `xfer_ovf_trig` at 1 and `xfer_keep_flag` at 0 clears the overflow flag. With `xfer_keep_flag` at 1, the flag stays set.
- R11: `irq_ovf` equals the overflow flag and `irq_unf` equals the underflow flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Current counter value of the channel |
| cnt_up | input | 1 | 1 while the counter counts up |
| phase_mode | input | 1 | Channel is in phase-counting mode |
| cpwm_mode | input | 1 | Channel is in complementary PWM mode |
| xfer_ovf_trig | input | 1 | Transfer controller was triggered by the overflow request |
| xfer_keep_flag | input | 1 | Transfer controller's disable-clear control; 1 keeps the flag |
| reg_rd | input | 1 | Decoded read strobe for this register |
| reg_wr | input | 1 | Decoded write strobe for this register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_unf | output | 1 | Underflow interrupt request |

## Verification
A corrupted flag shows on `reg_rdata` and on the matching interrupt line one cycle after the edge that corrupted it, because both outputs are driven straight from the flag register.

A stale or missing arm latch has no visible effect until the next 0-write. At that write, a flag either fails to clear or clears too early, so the bench always checks the readback in the cycle after each write. A wrong previous-counter register appears as a flag that sets on the wrong transition. For that reason, every wrap and non-wrap step is checked in the cycle right after it.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;

  localparam int REG_W   = 8;
  localparam int CNT_W   = 16;

  localparam int DIR_POS = 7;
  localparam int RSV_POS = 6;
  localparam int UNF_POS = 5;
  localparam int OVF_POS = 4;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_UNF = 1;
  localparam int N_FLAGS  = 2;

  function automatic bit chan_has_dir(input int ch);
    return ch != 0;
  endfunction

  function automatic bit chan_has_unf(input int ch);
    return (ch == 1) || (ch == 2);
  endfunction

  function automatic bit chan_has_cpwm(input int ch);
    return ch == 4;
  endfunction

  function automatic bit chan_has_xfer(input int ch);
    return ch == 4;
  endfunction

endpackage

// File: rtl/tmr_wrap_detect.sv
module tmr_wrap_detect #(
  parameter int  CNT_W    = 16,
  parameter bit  HAS_UNF  = 1'b1,
  parameter bit  HAS_CPWM = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             phase_mode,
  input  logic             cpwm_mode,
  output logic             ovf_evt,
  output logic             unf_evt
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO     = '0;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] prev_q;
  logic             prev_vld_q;
  logic             up_wrap, down_wrap, cpwm_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= ZERO;
      prev_vld_q <= 1'b0;
    end else begin
      prev_q     <= cnt_val;
      prev_vld_q <= 1'b1;
    end
  end

  always_comb begin
    up_wrap   = prev_vld_q && (prev_q == ALL_ONES) && (cnt_val == ZERO);
    down_wrap = prev_vld_q && (prev_q == ZERO) && (cnt_val == ALL_ONES);
    cpwm_hit  = prev_vld_q && HAS_CPWM && cpwm_mode
                && (prev_q == ONE) && (cnt_val == ZERO);
    ovf_evt   = up_wrap || cpwm_hit;
    unf_evt   = down_wrap && phase_mode && HAS_UNF;
  end

  AST_UNF_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |-> (phase_mode && cnt_val == ALL_ONES)); // R5

endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic hw_clr,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag_o
);

  logic flag_q, armed_q;
  logic set_ok, sw_clr, any_clr;

  always_comb begin
    set_ok  = set_evt && PRESENT;
    sw_clr  = wr_stb && !wr_bit && armed_q;
    any_clr = sw_clr || hw_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_ok)       flag_q <= 1'b1;
      else if (any_clr) flag_q <= 1'b0;

      if (any_clr)                armed_q <= 1'b0;
      else if (rd_stb && flag_q)  armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |=> flag_q); // R4

  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past((wr_stb && !wr_bit && armed_q) || hw_clr)); // R6

  AST_ONLY_HW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt)); // R7

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ok && any_clr) |=> flag_q); // R8

endmodule

// File: rtl/tmr_chan_status.sv
module tmr_chan_status
  import tmr_stat_pkg::*;
#(
  parameter int CHAN_IDX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_up,
  input  logic             phase_mode,
  input  logic             cpwm_mode,
  input  logic             xfer_ovf_trig,
  input  logic             xfer_keep_flag,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_ovf,
  output logic             irq_unf
);

  localparam bit HAS_DIR  = chan_has_dir(CHAN_IDX);
  localparam bit HAS_UNF  = chan_has_unf(CHAN_IDX);
  localparam bit HAS_CPWM = chan_has_cpwm(CHAN_IDX);
  localparam bit HAS_XFER = chan_has_xfer(CHAN_IDX);
  localparam logic [N_FLAGS-1:0] FLAG_PRESENT = {HAS_UNF, 1'b1};

  logic               dir_q;
  logic               ovf_evt, unf_evt, xfer_clr;
  logic [N_FLAGS-1:0] set_vec, hw_clr_vec, wbit_vec, flag_vec;
  logic               unused_wdata;

  assign unused_wdata = ^{reg_wdata[DIR_POS], reg_wdata[RSV_POS], reg_wdata[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= 1'b1;
    else        dir_q <= cnt_up || !HAS_DIR;
  end

  tmr_wrap_detect #(
    .CNT_W   (CNT_W),
    .HAS_UNF (HAS_UNF),
    .HAS_CPWM(HAS_CPWM)
  ) wrap_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_val   (cnt_val),
    .phase_mode(phase_mode),
    .cpwm_mode (cpwm_mode),
    .ovf_evt   (ovf_evt),
    .unf_evt   (unf_evt)
  );

  always_comb begin
    xfer_clr               = HAS_XFER && xfer_ovf_trig && !xfer_keep_flag;
    set_vec[FLAG_OVF]      = ovf_evt;
    set_vec[FLAG_UNF]      = unf_evt;
    hw_clr_vec[FLAG_OVF]   = xfer_clr;
    hw_clr_vec[FLAG_UNF]   = 1'b0;
    wbit_vec[FLAG_OVF]     = reg_wdata[OVF_POS];
    wbit_vec[FLAG_UNF]     = reg_wdata[UNF_POS];
  end

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    tmr_flag_cell #(.PRESENT(FLAG_PRESENT[g])) cell_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(set_vec[g]),
      .hw_clr (hw_clr_vec[g]),
      .rd_stb (reg_rd),
      .wr_stb (reg_wr),
      .wr_bit (wbit_vec[g]),
      .flag_o (flag_vec[g])
    );
  end

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[DIR_POS] = dir_q;
    reg_rdata[RSV_POS] = 1'b1;
    reg_rdata[UNF_POS] = flag_vec[FLAG_UNF];
    reg_rdata[OVF_POS] = flag_vec[FLAG_OVF];
  end

  assign irq_ovf = flag_vec[FLAG_OVF];
  assign irq_unf = flag_vec[FLAG_UNF];

  AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (reg_rdata[DIR_POS] == ($past(cnt_up) || !HAS_DIR))); // R2

  AST_IRQ_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> irq_ovf); // R11

  AST_XFER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_clr && !ovf_evt) |=> !irq_ovf); // R10

endmodule

// File: tb/tmr_chan_status_tb.sv
module tmr_chan_status_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_val = 16'h0;
  logic        cnt_up = 1'b1, phase_mode = 1'b0, cpwm_mode = 1'b0;
  logic        xfer_ovf_trig = 1'b0, xfer_keep_flag = 1'b0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h0;
  logic [7:0]  rd4, rd1, rd0;
  logic        io4, iu4, io1, iu1, io0, iu0;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tmr_chan_status #(.CHAN_IDX(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
    .phase_mode(phase_mode), .cpwm_mode(cpwm_mode),
    .xfer_ovf_trig(xfer_ovf_trig), .xfer_keep_flag(xfer_keep_flag),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd4), .irq_ovf(io4), .irq_unf(iu4));

  tmr_chan_status #(.CHAN_IDX(1)) dut_ch1_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
    .phase_mode(phase_mode), .cpwm_mode(cpwm_mode),
    .xfer_ovf_trig(xfer_ovf_trig), .xfer_keep_flag(xfer_keep_flag),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd1), .irq_ovf(io1), .irq_unf(iu1));

  tmr_chan_status #(.CHAN_IDX(0)) dut_ch0_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
    .phase_mode(phase_mode), .cpwm_mode(cpwm_mode),
    .xfer_ovf_trig(xfer_ovf_trig), .xfer_keep_flag(xfer_keep_flag),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd0), .irq_ovf(io0), .irq_unf(iu0));

  typedef struct packed {
    logic [15:0] cnt;
    logic        up;
    logic        ph;
    logic [7:0]  exp1;
    logic [7:0]  exp4;
  } vec_t;

  localparam int N_VEC = 5;
  localparam vec_t VECS [N_VEC] = '{
    '{16'hFFFE, 1'b1, 1'b1, 8'hC0, 8'hC0},
    '{16'hFFFF, 1'b1, 1'b1, 8'hC0, 8'hC0},
    '{16'h0000, 1'b1, 1'b1, 8'hD0, 8'hD0},
    '{16'hFFFF, 1'b0, 1'b1, 8'h70, 8'h50},
    '{16'hFFFE, 1'b0, 1'b1, 8'h70, 8'h50}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    reg_rd = 1'b1; step(); reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; step(); reg_wr = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ch4", rd4, 8'hC0);
    check("R1 ch1", rd1, 8'hC0);
    check("R1 ch0", rd0, 8'hC0);
    check("R1 irq", {io4, iu4, io1, iu1}, 8'h00);

    // table: R2 R4 R5
    for (int i = 0; i < N_VEC; i++) begin
      cnt_val = VECS[i].cnt;
      cnt_up = VECS[i].up;
      phase_mode = VECS[i].ph;
      step();
      check("R4/R5/R2 table ch1", rd1, VECS[i].exp1);
      check("R4/R5/R2 table ch4", rd4, VECS[i].exp4);
    end
    check("R2 R5 ch0 reserved", rd0, 8'hD0);
    check("R11 irqs", {6'b0, io1, iu1}, 8'h03);
    check("R11 ch4 unf", {7'b0, iu4}, 8'h00);

    // R6: zero write without a prior read
    do_write(8'h00);
    check("R6 unarmed write", rd1, 8'h70);
    do_read();
    check("R6 read keeps", rd1, 8'h70);
    // R7 and R3: write ones
    do_write(8'hFF);
    check("R7 R3 write ones", rd1, 8'h70);
    do_write(8'h00);
    check("R6 armed clear ch1", rd1, 8'h40);
    check("R6 armed clear ch4", rd4, 8'h40);
    check("R6 armed clear ch0", rd0, 8'hC0);
    check("R11 irq cleared", {6'b0, io1, iu1}, 8'h00);

    // R8 and non-phase underflow (R5)
    phase_mode = 1'b0;
    cnt_val = 16'hFFFF; step();
    cnt_val = 16'h0000; step();
    check("R4 reset flag again", rd1, 8'h50);
    do_read();
    cnt_val = 16'hFFFF; step();
    check("R5 no unf outside phase mode", rd1, 8'h50);
    cnt_val = 16'h0000;
    do_write(8'h00);
    check("R8 set wins", rd1, 8'h50);

    // clear all
    do_read();
    do_write(8'h00);
    check("R6 clear ch1", rd1, 8'h40);
    check("R6 clear ch4", rd4, 8'h40);

    // R9 complementary PWM on channel 4
    cpwm_mode = 1'b1;
    cnt_val = 16'h0001; step();
    cnt_val = 16'h0000; step();
    cpwm_mode = 1'b0;
    check("R9 ch4 set", rd4, 8'h50);
    check("R9 ch1 ignores", rd1, 8'h40);
    check("R11 ch4 irq", {7'b0, io4}, 8'h01);

    // R10 transfer controller clear
    xfer_ovf_trig = 1'b1; xfer_keep_flag = 1'b1; step();
    check("R10 keep", rd4, 8'h50);
    xfer_keep_flag = 1'b0; step();
    xfer_ovf_trig = 1'b0;
    check("R10 clear", rd4, 8'h40);
    check("R10 irq", {7'b0, io4}, 8'h00);

    // R2 direction back to up
    cnt_up = 1'b1; step();
    check("R2 ch1 up", rd1, 8'hC0);
    check("R2 ch0", rd0, 8'hC0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule